// File: doc/BRIEF.md
# Shared D-Channel Timeslot Access Arbiter

This block lets several HDLC controllers share one D-channel and command/indication timeslot on a frame-based serial bus. The bus line is open-drain style: a device either pulls the line low or leaves it released, so any driven zero overrides a one. Each frame is divided into bit slots, one bit per clock. In order, the slots are an access-available slot, the address slots, a stop/go slot and the D-channel data slots.

A local transmitter raises a request. The block waits for a frame whose access-available slot reads one. In that same frame it sends its own address, most significant bit first. It reads back every bit it sent on the falling clock edge. If a bit it left high comes back low, a lower address is also competing, so the block withdraws for the rest of the frame and keeps its request pending for a later frame. If the block confirms all of its address bits, it owns the bus. It then pulls the access-available slot low in every frame so that the other controllers stay out. From the frame after the win onward, it sends D-channel data in frames whose stop/go slot reads zero. When the transmitter signals that it is done, the block releases the bus.

Top module: `dca_access_arbiter`

## Requirements
- R1: During and right after reset the block pulls nothing on the line (`bus_pull`=0), and `tx_grant` and `tx_strobe` are 0.
- R2: When the access-available slot (slot 0 after a frame sync) reads 0, a pending request sends no address bit in that frame.
- R3: In the frame where slot 0 reads 1 and `tx_req` is high, the address is sent in slots 1 to ADR_W, most significant bit first. `bus_pull` is 1 in exactly the slots whose address bit is 0.
- R4: The line is a wired-AND, so among the requesters the lowest address wins. `tx_grant` rises in the slot after the last address slot, only for the winner.
- R5: A controller whose sampled bit differs from the bit it sent stops pulling in the next slot. It leaves all of its remaining address slots at one, and its `tx_grant` stays 0.
- R6: While `tx_grant` is 1, the block pulls slot 0 low in every frame.
- R7: Data is sent only from the frame after the win onward, and only in frames whose stop/go slot (slot ADR_W+1) reads 0. In those frames `tx_strobe` is 1 in the D_BITS data slots that follow, and `bus_pull` equals the inverse of `tx_bit`.
- R8: In a frame whose stop/go slot reads 1, `tx_strobe` stays 0 and `tx_grant` stays 1.
- R9: A `tx_done` pulse while granted clears `tx_grant` in the next slot. From the next frame on, slot 0 is no longer pulled low.
- R10: A controller that lost keeps its request and arbitrates again at the next frame whose slot 0 reads 1. It wins there if it has the lowest address still requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one slot per cycle; the line is sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High for one cycle; the next cycle is slot 0 |
| my_addr | input | ADR_W | Bus address of this controller; lower values have priority |
| bus_in | input | 1 | Resolved state of the shared line |
| bus_pull | output | 1 | 1 = pull the shared line low in this slot |
| tx_req | input | 1 | Local transmitter has a pending frame |
| tx_done | input | 1 | Local transmitter has finished; release the bus |
| tx_bit | input | 1 | Data bit to send while `tx_strobe` is high |
| tx_grant | output | 1 | This controller owns the bus |
| tx_strobe | output | 1 | Current slot carries this controller's data bit |

## Verification
A wrong state in the arbitration machine shows up on `bus_pull` within one slot. A controller that failed to withdraw still pulls an address slot after losing, and a stuck owner keeps slot 0 low in the following frame. A wrong data-enable state shows up in the data slots of the same frame as a `tx_strobe` in a stop frame, or as data sent in the win frame itself. The three-controller wired-AND bench compares each grant against the expected winner for that frame. This exposes priority errors on the slot right after the last address bit.

// File: rtl/dca_pkg.sv
package dca_pkg;

    // Meaning of the current bit slot inside a frame
    typedef enum logic [2:0] {
        SK_NONE,
        SK_AVAIL,
        SK_ADDR,
        SK_STOPGO,
        SK_DATA
    } slot_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONTEND,
        ST_OWNER
    } arb_state_e;

endpackage

// File: rtl/dca_slot_timer.sv
module dca_slot_timer
    import dca_pkg::*;
#(
    parameter int FRAME_LEN = 12,
    parameter int ADR_W     = 3,
    parameter int D_BITS    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_sync,
    output slot_kind_e              slot_kind,
    output logic [((ADR_W > 1) ? $clog2(ADR_W) : 1)-1:0] adr_idx,
    output logic                    last_slot
);
    localparam int CW       = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int IW       = (ADR_W > 1) ? $clog2(ADR_W) : 1;
    localparam int S_AVAIL  = 0;
    localparam int S_ADR0   = 1;
    localparam int S_STOPGO = S_ADR0 + ADR_W;
    localparam int S_DATA0  = S_STOPGO + 1;
    localparam int S_DEND   = S_DATA0 + D_BITS;

    typedef struct packed {
        logic          synced;
        logic [CW-1:0] slot;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (frame_sync) begin
            tmr_d.synced = 1'b1;
            tmr_d.slot   = '0;
        end else if (tmr_q.synced) begin
            tmr_d.slot = (tmr_q.slot == CW'(FRAME_LEN - 1)) ? '0 : tmr_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    logic [CW-1:0] rel_slot;

    always_comb begin
        rel_slot  = tmr_q.slot - CW'(S_ADR0);
        adr_idx   = IW'(rel_slot);
        last_slot = tmr_q.synced && (tmr_q.slot == CW'(FRAME_LEN - 1));
        slot_kind = SK_NONE;
        if (tmr_q.synced) begin
            if (tmr_q.slot == CW'(S_AVAIL))
                slot_kind = SK_AVAIL;
            else if (tmr_q.slot >= CW'(S_ADR0) && tmr_q.slot < CW'(S_STOPGO))
                slot_kind = SK_ADDR;
            else if (tmr_q.slot == CW'(S_STOPGO))
                slot_kind = SK_STOPGO;
            else if (tmr_q.slot >= CW'(S_DATA0) && tmr_q.slot < CW'(S_DEND))
                slot_kind = SK_DATA;
        end
    end

endmodule

// File: rtl/dca_line_sampler.sv
module dca_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_smp
);
    logic smp_d, smp_q;

    always_comb smp_d = line_in;

    // Read-back happens mid-slot, on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= 1'b1;
        else        smp_q <= smp_d;
    end

    assign line_smp = smp_q;

endmodule

// File: rtl/dca_arb_fsm.sv
module dca_arb_fsm
    import dca_pkg::*;
#(
    parameter int ADR_W = 3
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  slot_kind_e                                    slot_kind,
    input  logic [((ADR_W > 1) ? $clog2(ADR_W) : 1)-1:0]  adr_idx,
    input  logic                                          last_slot,
    input  logic                                          line_smp,
    input  logic [ADR_W-1:0]                              my_addr,
    input  logic                                          tx_req,
    input  logic                                          tx_done,
    input  logic                                          tx_bit,
    output logic                                          bus_pull,
    output logic                                          tx_grant,
    output logic                                          tx_strobe,
    output logic                                          contending,
    output logic                                          sent_bit
);
    localparam int IW = (ADR_W > 1) ? $clog2(ADR_W) : 1;

    typedef struct packed {
        arb_state_e st;
        logic       data_go;   // stop/go read zero in this frame
        logic       won_now;   // still inside the frame of the win
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    // Address bit for the current address slot, most significant first
    always_comb begin
        sent_bit = 1'b1;
        for (int k = 0; k < ADR_W; k++) begin
            if (int'(adr_idx) == k) sent_bit = my_addr[ADR_W-1-k];
        end
    end

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (slot_kind == SK_AVAIL && tx_req && line_smp)
                    fsm_d.st = ST_CONTEND;
            end
            ST_CONTEND: begin
                if (slot_kind == SK_ADDR) begin
                    if (line_smp != sent_bit) begin
                        fsm_d.st = ST_IDLE;
                    end else if (adr_idx == IW'(ADR_W - 1)) begin
                        fsm_d.st      = ST_OWNER;
                        fsm_d.won_now = 1'b1;
                        fsm_d.data_go = 1'b0;
                    end
                end
            end
            ST_OWNER: begin
                if (tx_done) begin
                    fsm_d.st      = ST_IDLE;
                    fsm_d.data_go = 1'b0;
                    fsm_d.won_now = 1'b0;
                end else begin
                    if (slot_kind == SK_STOPGO)
                        fsm_d.data_go = !line_smp && !fsm_q.won_now;
                    if (last_slot)
                        fsm_d.won_now = 1'b0;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, data_go: 1'b0, won_now: 1'b0};
        else        fsm_q <= fsm_d;
    end

    always_comb begin
        contending = (fsm_q.st == ST_CONTEND);
        tx_grant   = (fsm_q.st == ST_OWNER);
        tx_strobe  = tx_grant && fsm_q.data_go && (slot_kind == SK_DATA);
        bus_pull   = (contending && slot_kind == SK_ADDR && !sent_bit)
                   || (tx_grant && slot_kind == SK_AVAIL)
                   || (tx_strobe && !tx_bit);
    end

endmodule

// File: rtl/dca_access_arbiter.sv
module dca_access_arbiter
    import dca_pkg::*;
#(
    parameter int FRAME_LEN = 12,
    parameter int ADR_W     = 3,
    parameter int D_BITS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic [ADR_W-1:0] my_addr,
    input  logic             bus_in,
    output logic             bus_pull,
    input  logic             tx_req,
    input  logic             tx_done,
    input  logic             tx_bit,
    output logic             tx_grant,
    output logic             tx_strobe
);
    localparam int IW = (ADR_W > 1) ? $clog2(ADR_W) : 1;

    slot_kind_e    slot_kind;
    logic [IW-1:0] adr_idx;
    logic          last_slot;
    logic          line_smp;
    logic          contending;
    logic          sent_bit;

    dca_slot_timer #(
        .FRAME_LEN (FRAME_LEN),
        .ADR_W     (ADR_W),
        .D_BITS    (D_BITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .slot_kind  (slot_kind),
        .adr_idx    (adr_idx),
        .last_slot  (last_slot)
    );

    dca_line_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (bus_in),
        .line_smp (line_smp)
    );

    dca_arb_fsm #(
        .ADR_W (ADR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_kind  (slot_kind),
        .adr_idx    (adr_idx),
        .last_slot  (last_slot),
        .line_smp   (line_smp),
        .my_addr    (my_addr),
        .tx_req     (tx_req),
        .tx_done    (tx_done),
        .tx_bit     (tx_bit),
        .bus_pull   (bus_pull),
        .tx_grant   (tx_grant),
        .tx_strobe  (tx_strobe),
        .contending (contending),
        .sent_bit   (sent_bit)
    );

endmodule

// File: rtl/dca_access_arbiter_chk.sv
module dca_access_arbiter_chk
    import dca_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_pull,
    input logic       tx_grant,
    input logic       tx_strobe,
    input slot_kind_e slot_kind,
    input logic       contending,
    input logic       line_smp,
    input logic       sent_bit
);
    // Neither contending nor owning: all lines released
    assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_grant && !contending) |-> !bus_pull);

    // A mismatching read-back ends contention at once
    assert_loss_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (contending && slot_kind == SK_ADDR && line_smp != sent_bit) |=> (!contending && !tx_grant));

    // Contention starts only after an access slot read as one
    assert_avail_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(contending) |-> $past(slot_kind == SK_AVAIL && line_smp));

    // Ownership follows a completed contention
    assert_grant_after_contend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_grant) |-> $past(contending));

    // Owner blocks the access slot
    assert_owner_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && slot_kind == SK_AVAIL) |-> bus_pull);

    // Data strobes only for the owner, only in data slots
    assert_strobe_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> (tx_grant && slot_kind == SK_DATA));

endmodule

bind dca_access_arbiter dca_access_arbiter_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_pull   (bus_pull),
    .tx_grant   (tx_grant),
    .tx_strobe  (tx_strobe),
    .slot_kind  (slot_kind),
    .contending (contending),
    .line_smp   (line_smp),
    .sent_bit   (sent_bit)
);

// File: tb/dca_access_arbiter_tb.sv
module dca_access_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FL         = 12;
    localparam int AW         = 3;
    localparam int DB         = 4;
    localparam int NC         = 3;
    localparam int SLOT_SG    = 1 + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_sync = 1'b0;
    logic [AW-1:0] addr [NC];
    logic [NC-1:0] pull, grant, strobe;
    logic [NC-1:0] req = '0;
    logic [NC-1:0] done = '0;
    logic [NC-1:0] txb = '0;
    logic          ext_avail_low = 1'b1;
    logic          sg_go = 1'b0;
    logic          line;
    int            tb_slot = 0;
    bit            tb_synced = 1'b0;
    int            checks = 0;
    int            fails = 0;
    bit            finished = 1'b0;
    int            exp_q [$];
    logic [NC-1:0] grant_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        addr[0] = 3'd5;
        addr[1] = 3'd2;
        addr[2] = 3'd6;
    end

    // Wired-AND line: any pull, the foreign owner or the line side drives zero
    always_comb line = !((|pull) || (ext_avail_low && tb_slot == 0 && tb_synced)
                         || (sg_go && tb_slot == SLOT_SG && tb_synced));

    for (genvar i = 0; i < NC; i++) begin : g_ctl
        dca_access_arbiter #(.FRAME_LEN(FL), .ADR_W(AW), .D_BITS(DB)) dut_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_sync (frame_sync),
            .my_addr    (addr[i]),
            .bus_in     (line),
            .bus_pull   (pull[i]),
            .tx_req     (req[i]),
            .tx_done    (done[i]),
            .tx_bit     (txb[i]),
            .tx_grant   (grant[i]),
            .tx_strobe  (strobe[i])
        );
    end

    // Bench-side slot position
    always @(posedge clk) begin
        if (frame_sync) begin
            tb_slot   <= 0;
            tb_synced <= 1'b1;
        end else if (tb_synced) begin
            tb_slot <= (tb_slot == FL - 1) ? 0 : tb_slot + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_win(input int idx);
        exp_q.push_back(idx);
    endtask

    // Advance to the next occurrence of slot s, then settle before sampling
    task automatic at_slot(input int s);
        do begin
            @(posedge clk);
            #1;
        end while (tb_slot != s);
    endtask

    task automatic settle();
        #(CLK_PERIOD/2 - 2);
    endtask

    // Scoreboard monitor: each rising grant must match the next expected winner
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NC; i++) begin
                if (grant[i] && !grant_prev[i]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected grant", i, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(e == i, "R4 winner", i, e);
                    end
                end
            end
            chk($countones(grant) <= 1, "R4 single owner", $countones(grant), 1);
        end
        grant_prev <= grant;
    end

    // Frame sync generator
    initial begin
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1;
            frame_sync = 1'b1;
            @(posedge clk);
            #1;
            frame_sync = 1'b0;
            repeat (FL - 2) @(posedge clk);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < NC; i++) begin
            chk(pull[i] == 1'b0,   "R1 pull in reset",   pull[i],   0);
            chk(grant[i] == 1'b0,  "R1 grant in reset",  grant[i],  0);
            chk(strobe[i] == 1'b0, "R1 strobe in reset", strobe[i], 0);
        end
        req   = '1;
        rst_n = 1'b1;
        wait (tb_synced);

        // Frame A: a foreign owner holds the access slot low
        for (int s = 1; s <= AW; s++) begin
            at_slot(s);
            settle();
            chk(pull == '0, "R2 no address while blocked", pull, 0);
        end
        at_slot(SLOT_SG);
        ext_avail_low = 1'b0;

        // Frame B: addresses 5, 2, 6 contend; 2 (binary 010) wins
        at_slot(1);
        settle();
        chk(pull[1] == 1'b1, "R3 msb zero pulled", pull[1], 1);
        chk(pull[0] == 1'b0 && pull[2] == 1'b0, "R3 msb one released", {pull[0], pull[2]}, 0);
        expect_win(1);
        at_slot(2);
        settle();
        chk(pull[0] == 1'b0 && pull[2] == 1'b0, "R5 losers released", {pull[0], pull[2]}, 0);
        at_slot(3);
        settle();
        chk(pull[1] == 1'b1, "R3 lsb zero pulled", pull[1], 1);
        chk(pull[0] == 1'b0 && pull[2] == 1'b0, "R5 losers stay released", {pull[0], pull[2]}, 0);
        at_slot(SLOT_SG);
        sg_go = 1'b1;
        settle();
        chk(grant == 3'b010, "R4 only lowest granted", grant, 2);
        at_slot(SLOT_SG + 1);
        settle();
        chk(strobe[1] == 1'b0, "R7 no data in win frame", strobe[1], 0);

        // Frame C: owner blocks access and sends data
        at_slot(0);
        settle();
        chk(pull[1] == 1'b1, "R6 owner pulls access slot", pull[1], 1);
        at_slot(SLOT_SG + 1);
        settle();
        chk(strobe[1] == 1'b1, "R7 strobe when go", strobe[1], 1);
        chk(pull[1] == 1'b1, "R7 zero data pulled", pull[1], 1);
        at_slot(SLOT_SG + 2);
        txb[1] = 1'b1;
        sg_go  = 1'b0;
        settle();
        chk(pull[1] == 1'b0, "R7 one data released", pull[1], 0);

        // Frame D: stop/go reads one
        at_slot(SLOT_SG + 1);
        settle();
        chk(strobe[1] == 1'b0, "R8 no strobe on stop", strobe[1], 0);
        chk(grant[1] == 1'b1, "R8 ownership kept", grant[1], 1);
        at_slot(SLOT_SG + 2);
        done[1] = 1'b1;
        req[1]  = 1'b0;
        expect_win(0);
        at_slot(SLOT_SG + 3);
        done[1] = 1'b0;
        settle();
        chk(grant[1] == 1'b0, "R9 grant cleared", grant[1], 0);

        // Frame E: released; 5 (101) beats 6 (110) on the middle bit
        at_slot(0);
        settle();
        chk(pull == '0, "R9 access slot released", pull, 0);
        at_slot(2);
        settle();
        chk(pull[0] == 1'b1 && pull[2] == 1'b0, "R10 retry contention", pull, 1);
        at_slot(SLOT_SG);
        settle();
        chk(grant == 3'b001, "R10 retrying loser wins", grant, 1);

        // Frame F: owner 0 finishes; frame G: last requester wins alone
        at_slot(2);
        done[0] = 1'b1;
        req[0]  = 1'b0;
        expect_win(2);
        at_slot(3);
        done[0] = 1'b0;
        at_slot(3);
        settle();
        chk(pull[2] == 1'b1, "R3 lone contender lsb", pull[2], 1);
        at_slot(SLOT_SG);
        settle();
        chk(grant == 3'b100, "R10 final winner", grant, 4);
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R4 all expected grants seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule